// File: doc/BRIEF.md
# Multiplexed DRAM Strobe Sequencer

This block sits between a single client and an asynchronous one-bit-wide DRAM whose row and column addresses share a 10-bit bus. The client issues one of three commands: store a bit, fetch a bit, or run a refresh burst. For stores and fetches the block latches a 10-bit row and a 10-bit column, so the addressable space is 20 bits (1M locations). It then steps the active-low row strobe, column strobe and write enable through a fixed sequence. The row goes out first, then the column.

A refresh burst uses CAS-before-RAS cycles. The DRAM's own row counter supplies the refresh address, so the address bus carries no meaning during a burst. Every phase of every sequence lasts a parameterised number of clocks. Setting those counts sets the strobe widths, the address setup and the precharge time to match the attached part. A one-cycle done pulse closes each command, and a fetched bit is valid from that pulse onward.

Top module: `dram_strobe_seq`

## Requirements
- R1: After reset and whenever idle, ras_no, cas_no and we_no are high, busy_o and done_o are low, and dq_oe_o is low.
- R2: For a read or write, the row is on addr_o when ras_no falls with cas_no high, and the column is on addr_o when cas_no later falls with ras_no low.
- R3: For a write, we_no is low, dq_oe_o is high and dq_o equals the latched data bit when cas_no falls.
- R4: For a read, we_no stays high. rdata_o holds the value of dq_i sampled in the last clock of the column-strobe phase, and it is valid when done_o pulses.
- R5: A refresh command runs REFRESH_CYCLES cycles (default 8). In each cycle cas_no falls, then ras_no falls while cas_no is low, then cas_no rises, then ras_no rises. No row/column access occurs during the burst.
- R6: Taking the accepting edge as edge 0, done_o is high in the cycle after edge L. L is 4*T_SETUP+2*T_STROBE+T_PRE for a write, 3*T_SETUP+2*T_STROBE+T_PRE for a read, and REFRESH_CYCLES*(2*T_SETUP+T_STROBE+T_PRE) for a refresh.
- R7: busy_o is high from the cycle after acceptance until done_o pulses. A command presented while busy_o is high is ignored.
- R8: cmd_op_i encodes 0 = read, 1 = write, 2 = refresh, 3 = no operation. Code 3 with cmd_valid_i is ignored and starts nothing.
- R9: dq_oe_o is high only during a write.
- R10: At the end of a read or write, the strobes release in this order: we_no rises while ras_no and cas_no are still low (write only), then ras_no rises while cas_no is low, then cas_no rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command request, taken when idle |
| cmd_op_i | input | 2 | 0 read, 1 write, 2 refresh, 3 none |
| row_i | input | 10 | Row address |
| col_i | input | 10 | Column address |
| wdata_i | input | 1 | Bit to store |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 1 | Fetched bit |
| addr_o | output | 10 | Multiplexed DRAM address |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| we_no | output | 1 | Write enable, active low |
| dq_o | output | 1 | Data toward the DRAM |
| dq_oe_o | output | 1 | Data pin drive enable |
| dq_i | input | 1 | Data from the DRAM |

## Verification
Each command is driven on a falling edge and taken on the next rising edge. The bench then counts falling edges until done_o appears and compares the count with L+1 from R6, so a single missing or extra phase clock shows up as a latency mismatch. Strobe ordering, bus contents and write data are checked on the falling edge after each strobe transition, because all DRAM-side outputs are registered. The bench's DRAM model drives dq_i on the falling edge once both strobes are low, which is ahead of the rising edge that captures it, and rdata_o is compared on the done cycle.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;

  typedef enum logic [1:0] {
    OP_READ    = 2'd0,
    OP_WRITE   = 2'd1,
    OP_REFRESH = 2'd2,
    OP_NONE    = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_WEUP,
    ST_RASUP,
    ST_PRE,
    ST_RF_CAS,
    ST_RF_RAS,
    ST_RF_CASUP,
    ST_RF_PRE
  } st_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
    logic sel_col;
    logic oe;
  } pins_t;

  function automatic pins_t pins_of(st_e s, op_e op);
    pins_t p;
    logic  wr;
    wr = (op == OP_WRITE);
    p  = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, sel_col: 1'b0, oe: 1'b0};
    case (s)
      ST_RAS:      begin p.ras_n = 1'b0; p.oe = wr; end
      ST_COL:      begin p.ras_n = 1'b0; p.sel_col = 1'b1; p.we_n = ~wr; p.oe = wr; end
      ST_CAS:      begin p.ras_n = 1'b0; p.cas_n = 1'b0; p.sel_col = 1'b1; p.we_n = ~wr; p.oe = wr; end
      ST_WEUP:     begin p.ras_n = 1'b0; p.cas_n = 1'b0; p.sel_col = 1'b1; p.oe = wr; end
      ST_RASUP:    begin p.cas_n = 1'b0; p.sel_col = 1'b1; end
      ST_RF_CAS:   p.cas_n = 1'b0;
      ST_RF_RAS:   begin p.cas_n = 1'b0; p.ras_n = 1'b0; end
      ST_RF_CASUP: p.ras_n = 1'b0;
      default:     ;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dram_phase_timer.sv
module dram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_timer_no_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/dram_burst_ctr.sv
module dram_burst_ctr #(
  parameter int N = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic dec_i,
  output logic last_o
);
  localparam int W = $clog2(N + 1);
  logic [W-1:0] rem_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  rem_q <= '0;
    else if (load_i)              rem_q <= W'(N);
    else if (dec_i && rem_q != 0) rem_q <= rem_q - 1'b1;
  end

  assign last_o = (rem_q <= W'(1));

  p_burst_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_q <= W'(N));
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_seq_pkg::*;
#(
  parameter int ADDR_W         = 10,
  parameter int T_SETUP        = 1,
  parameter int T_STROBE       = 2,
  parameter int T_PRE          = 2,
  parameter int REFRESH_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [1:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] row_i,
  input  logic [ADDR_W-1:0] col_i,
  input  logic              wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rdata_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic              dq_o,
  output logic              dq_oe_o,
  input  logic              dq_i
);
  localparam int MAX_A = (T_SETUP > T_STROBE) ? T_SETUP : T_STROBE;
  localparam int MAX_H = (MAX_A > T_PRE) ? MAX_A : T_PRE;
  localparam int TW    = $clog2(MAX_H + 1);

  st_e               state_q, state_d;
  op_e               op_q;
  logic [ADDR_W-1:0] row_q, col_q;
  logic              wdata_q;
  logic              accept, phase_end, tmr_zero, burst_last, tmr_load;
  logic [TW-1:0]     tmr_val;
  pins_t             pins_d;

  function automatic logic [TW-1:0] hold_of(st_e s);
    case (s)
      ST_RAS, ST_CAS, ST_RF_RAS: return TW'(T_STROBE - 1);
      ST_PRE, ST_RF_PRE:         return TW'(T_PRE - 1);
      default:                   return TW'(T_SETUP - 1);
    endcase
  endfunction

  assign accept    = (state_q == ST_IDLE) && cmd_valid_i && (op_e'(cmd_op_i) != OP_NONE);
  assign phase_end = (state_q != ST_IDLE) && tmr_zero;

  always_comb begin
    state_d = state_q;
    if (accept) begin
      state_d = (op_e'(cmd_op_i) == OP_REFRESH) ? ST_RF_CAS : ST_ROW;
    end else if (phase_end) begin
      case (state_q)
        ST_ROW:      state_d = ST_RAS;
        ST_RAS:      state_d = ST_COL;
        ST_COL:      state_d = ST_CAS;
        ST_CAS:      state_d = (op_q == OP_WRITE) ? ST_WEUP : ST_RASUP;
        ST_WEUP:     state_d = ST_RASUP;
        ST_RASUP:    state_d = ST_PRE;
        ST_PRE:      state_d = ST_IDLE;
        ST_RF_CAS:   state_d = ST_RF_RAS;
        ST_RF_RAS:   state_d = ST_RF_CASUP;
        ST_RF_CASUP: state_d = ST_RF_PRE;
        ST_RF_PRE:   state_d = burst_last ? ST_IDLE : ST_RF_CAS;
        default:     state_d = ST_IDLE;
      endcase
    end
  end

  assign tmr_load = (state_d != state_q) && (state_d != ST_IDLE);
  assign tmr_val  = hold_of(state_d);
  assign pins_d   = pins_of(state_d, accept ? op_e'(cmd_op_i) : op_q);

  dram_phase_timer #(.W(TW)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (tmr_load),
    .val_i  (tmr_val),
    .zero_o (tmr_zero)
  );

  dram_burst_ctr #(.N(REFRESH_CYCLES)) u_burst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (accept),
    .dec_i  (phase_end && state_q == ST_RF_PRE),
    .last_o (burst_last)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      row_q   <= '0;
      col_q   <= '0;
      wdata_q <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= 1'b0;
      addr_o  <= '0;
      ras_no  <= 1'b1;
      cas_no  <= 1'b1;
      we_no   <= 1'b1;
      dq_o    <= 1'b0;
      dq_oe_o <= 1'b0;
    end else begin
      state_q <= state_d;
      done_o  <= (state_q != ST_IDLE) && (state_d == ST_IDLE);
      if (accept) begin
        op_q    <= op_e'(cmd_op_i);
        row_q   <= row_i;
        col_q   <= col_i;
        wdata_q <= wdata_i;
        dq_o    <= wdata_i;
      end
      if (state_q == ST_CAS && phase_end && op_q == OP_READ) rdata_o <= dq_i;
      addr_o  <= pins_d.sel_col ? (accept ? col_i : col_q) : (accept ? row_i : row_q);
      ras_no  <= pins_d.ras_n;
      cas_no  <= pins_d.cas_n;
      we_no   <= pins_d.we_n;
      dq_oe_o <= pins_d.oe;
    end
  end

  assign busy_o = (state_q != ST_IDLE);

  p_idle_strobes_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ras_no && cas_no && we_no && !dq_oe_o));
  p_col_after_row_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_no) && op_q != OP_REFRESH) |-> !ras_no);
  p_we_before_cas_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(cas_no) && op_q == OP_WRITE) |-> (!we_no && dq_o == wdata_q));
  p_read_we_high_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && op_q == OP_READ) |-> we_no);
  p_cbr_order_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && op_q == OP_REFRESH) |-> !cas_no);
  p_done_ends_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  p_oe_write_only_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (op_q == OP_WRITE));
  p_ras_up_first_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ras_no) && op_q != OP_REFRESH) |-> (!cas_no && we_no));
  p_we_low_needs_ras_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_no |-> !ras_no);
endmodule

// File: tb/dram_strobe_seq_tb.sv
module dram_strobe_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int TS = 1, TST = 2, TP = 2, NREF = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cmd_valid_i = 1'b0;
  logic [1:0] cmd_op_i = 2'd3;
  logic [AW-1:0] row_i = '0, col_i = '0;
  logic wdata_i = 1'b0, dq_i = 1'b0;
  logic busy_o, done_o, rdata_o, ras_no, cas_no, we_no, dq_o, dq_oe_o;
  logic [AW-1:0] addr_o;

  int n_checks = 0, n_fail = 0;
  int ras_acc = 0, ref_cyc = 0;
  logic [1:0] cur_op = 2'd3;
  logic [AW-1:0] cur_row = '0, cur_col = '0, lat_row = '0;
  logic cur_data = 1'b0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;
  bit model_mem[int];
  bit exp_mem[int];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dram_strobe_seq #(.ADDR_W(AW), .T_SETUP(TS), .T_STROBE(TST), .T_PRE(TP),
                    .REFRESH_CYCLES(NREF)) u_dut (
    .clk_i, .rst_ni, .cmd_valid_i, .cmd_op_i, .row_i, .col_i, .wdata_i,
    .busy_o, .done_o, .rdata_o, .addr_o, .ras_no, .cas_no, .we_no,
    .dq_o, .dq_oe_o, .dq_i);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int lat_of(input logic [1:0] op);
    case (op)
      2'd0:    return 3*TS + 2*TST + TP;
      2'd1:    return 4*TS + 2*TST + TP;
      default: return NREF * (2*TS + TST + TP);
    endcase
  endfunction

  // bench DRAM model and strobe monitor
  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (prev_ras && !ras_no) begin
        if (cas_no) begin
          ras_acc++;
          chk(addr_o == cur_row, "R2 row", int'(addr_o), int'(cur_row));
          lat_row = addr_o;
        end else ref_cyc++;
      end
      if (prev_cas && !cas_no && !ras_no) begin
        chk(addr_o == cur_col, "R2 col", int'(addr_o), int'(cur_col));
        if (cur_op == 2'd1) begin
          chk(!we_no && dq_oe_o && dq_o == cur_data, "R3", int'({we_no, dq_oe_o, dq_o}),
              int'({1'b0, 1'b1, cur_data}));
          model_mem[int'({lat_row, addr_o})] = dq_o;
        end else
          chk(we_no && !dq_oe_o, "R4 we", int'({we_no, dq_oe_o}), 2);
      end
      if (prev_cas && !cas_no && ras_no)
        chk(cur_op == 2'd2, "R5 cbr", int'(cur_op), 2);
      if (!prev_ras && ras_no && cur_op != 2'd2)
        chk(!cas_no && we_no, "R10 ras", int'({cas_no, we_no}), 1);
      if (!prev_cas && cas_no && cur_op != 2'd2)
        chk(ras_no, "R10 cas", int'(ras_no), 1);
      if (dq_oe_o) chk(cur_op == 2'd1, "R9", int'(cur_op), 1);
      dq_i = (!ras_no && !cas_no && we_no) ?
             (model_mem.exists(int'({lat_row, addr_o})) ? model_mem[int'({lat_row, addr_o})] : 1'b0)
             : 1'b0;
    end
    prev_ras = ras_no;
    prev_cas = cas_no;
  end

  task automatic run_cmd(input logic [1:0] op, input logic [AW-1:0] r, input logic [AW-1:0] c,
                         input logic d, input bit poke_busy);
    int n, acc0, ref0;
    acc0 = ras_acc; ref0 = ref_cyc;
    @(negedge clk_i);
    cur_op = op; cur_row = r; cur_col = c; cur_data = d;
    cmd_valid_i = 1'b1; cmd_op_i = op; row_i = r; col_i = c; wdata_i = d;
    @(negedge clk_i);
    n = 1;
    chk(busy_o, "R7 busy", int'(busy_o), 1);
    if (poke_busy) begin
      cmd_op_i = (op == 2'd1) ? 2'd0 : 2'd1;
      row_i = ~r; col_i = ~c; wdata_i = ~d;
    end else cmd_valid_i = 1'b0;
    while (!done_o && n < 1000) begin
      @(negedge clk_i);
      n++;
    end
    cmd_valid_i = 1'b0;
    chk(n == lat_of(op) + 1, "R6 latency", n, lat_of(op) + 1);
    chk(!busy_o, "R7 busy at done", int'(busy_o), 0);
    if (op == 2'd2) begin
      chk(ref_cyc - ref0 == NREF, "R5 count", ref_cyc - ref0, NREF);
      chk(ras_acc == acc0, "R5 no access", ras_acc - acc0, 0);
    end else begin
      chk(ras_acc - acc0 == 1, "R7 one access", ras_acc - acc0, 1);
      chk(ref_cyc == ref0, "R5 no cbr", ref_cyc - ref0, 0);
    end
    if (op == 2'd1) exp_mem[int'({r, c})] = d;
    if (op == 2'd0) begin
      logic e;
      e = exp_mem.exists(int'({r, c})) ? exp_mem[int'({r, c})] : 1'b0;
      chk(rdata_o == e, "R4 rdata", int'(rdata_o), int'(e));
    end
    @(negedge clk_i);
    chk(done_o == 1'b0, "R6 pulse", int'(done_o), 0);
    chk(ras_no && cas_no && we_no && !busy_o, "R1 idle", int'({ras_no, cas_no, we_no, busy_o}), 14);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    logic [AW-1:0] rows[4];
    logic [AW-1:0] cols[4];
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk_i);
    chk(ras_no && cas_no && we_no, "R1 strobes in reset", int'({ras_no, cas_no, we_no}), 7);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(ras_no && cas_no && we_no && !busy_o && !done_o && !dq_oe_o, "R1 reset",
        int'({ras_no, cas_no, we_no, busy_o, done_o, dq_oe_o}), 56);

    run_cmd(2'd1, '0, '0, 1'b1, 1'b0);
    run_cmd(2'd1, '1, '1, 1'b1, 1'b0);
    run_cmd(2'd1, 10'h155, 10'h2AA, 1'b0, 1'b0);
    run_cmd(2'd0, '0, '0, 1'b0, 1'b0);
    run_cmd(2'd0, '1, '1, 1'b0, 1'b0);
    run_cmd(2'd0, 10'h155, 10'h2AA, 1'b0, 1'b0);
    run_cmd(2'd2, '0, '0, 1'b0, 1'b0);

    // R7: requests held during busy are ignored
    run_cmd(2'd1, 10'h3, 10'h7, 1'b1, 1'b1);
    run_cmd(2'd0, 10'h3, 10'h7, 1'b0, 1'b1);
    run_cmd(2'd2, 10'h0, 10'h0, 1'b0, 1'b1);
    run_cmd(2'd0, ~10'h3, ~10'h7, 1'b0, 1'b0);

    // R8: op code 3 starts nothing
    begin
      int acc0, ref0;
      acc0 = ras_acc; ref0 = ref_cyc;
      cur_op = 2'd3;
      cmd_valid_i = 1'b1; cmd_op_i = 2'd3;
      repeat (5) begin
        @(negedge clk_i);
        chk(!busy_o && ras_no && cas_no, "R8 busy", int'(busy_o), 0);
      end
      cmd_valid_i = 1'b0;
      chk(ras_acc == acc0 && ref_cyc == ref0, "R8 no strobes", ras_acc - acc0, 0);
    end

    for (int i = 0; i < 4; i++) begin
      rows[i] = AW'($urandom);
      cols[i] = AW'($urandom);
    end
    for (int i = 0; i < 60; i++) begin
      int k, o;
      k = int'($urandom_range(3, 0));
      o = int'($urandom_range(9, 0));
      if (o < 4)      run_cmd(2'd1, rows[k], cols[k], 1'($urandom), 1'b0);
      else if (o < 9) run_cmd(2'd0, rows[k], cols[k], 1'b0, 1'($urandom));
      else            run_cmd(2'd2, '0, '0, 1'b0, 1'b0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule